// File: doc/BRIEF.md
# Windowed Command and Status Port

This block is the host-facing command and event-status port of a network controller. The host writes 16-bit command words, each holding an opcode in the upper five bits and an 11-bit parameter in the lower eleven. Through these commands it selects one of eight register windows, sets two event masks, acknowledges latched events and resets the port as a whole. The selected window number is driven to a neighbouring register bank, so eight sets of registers can share one small offset range.

Reading the port returns a status word. It carries the selected window, a busy flag that stays high for a fixed number of cycles after each accepted command, and the latched event flags that the indication mask lets through. Event sources deliver single-cycle pulses. Bit 0 of the status word is an interrupt summary, and the `irq_o` output follows it. A command written while the port is busy is dropped and sets a sticky error flag. A global reset command also sends a one-cycle strobe that clears the station mask registers held elsewhere.

Top module: `ccp_cmd_port`

## Requirements
- R1: A command word has its opcode in bits 15:11 and its parameter in bits 10:0. It is accepted on a clock edge where `cmd_wr` is high and the port is not busy, and its effect shows from the next cycle on.
- R2: Status word layout: bits 15:13 hold the selected window, bit 12 is busy, bit 11 reads 0, and bits 10:1 are event flags that are latched and enabled in the indication mask. Event positions are: 1 host error, 2 transmit done, 4 receive done, 5 receive early, 6 interrupt requested, 7 statistics update, 8 link change, 9 download done, 10 upload done. Bit 3 reads 0.
- R3: Opcode 0x01 selects the window given by parameter bits 2:0 and drives it on `win_sel_o`. Higher parameter bits are ignored. The window changes only through an accepted command.
- R4: An event pulse on `evt_i` latches its bit whether or not that bit is enabled in the indication mask. Opcode 0x0F loads the indication mask from the parameter, and this mask only decides whether latched bits are visible.
- R5: Opcode 0x0D clears every latched event bit whose position is set in the parameter and leaves all other bits as they were.
- R6: When an event pulse arrives on the same edge as an acknowledge of that bit, the bit stays set.
- R7: Opcode 0x0E loads the interrupt-enable mask. Status bit 0 and `irq_o` are the OR of all events that are both latched and interrupt-enabled, regardless of the indication mask.
- R8: After an accepted command, status bit 12 reads 1 for exactly BUSY_CYCLES cycles.
- R9: A command written while busy has no effect and sets `cmd_err_o`, which stays set until a global reset command or `rst_n`.
- R10: Opcode 0x00 clears the window to 0, both masks, all latched events (an event pulse on the same edge included) and `cmd_err_o`. It raises `sta_clr_o` for exactly one cycle and starts the busy period.
- R11: After `rst_n` the window is 0, both masks are zero, no event is latched, busy is 0, and `cmd_err_o`, `sta_clr_o` and `irq_o` are 0.
- R12: `evt_i` bits 0 and 3 are ignored. An opcode with no defined function starts the busy period and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode 15:11, parameter 10:0 |
| evt_i | input | 11 | Single-cycle event pulses, one per status bit position |
| status_o | output | 16 | Status word |
| win_sel_o | output | 3 | Selected register window |
| irq_o | output | 1 | Interrupt request, equal to status bit 0 |
| cmd_err_o | output | 1 | Sticky flag: a command was written while busy |
| sta_clr_o | output | 1 | One-cycle strobe that clears the station mask registers |

## Verification
The bench builds the port with BUSY_CYCLES set to 3. This keeps the busy window short enough that a second write falling on the cycle right after an accepted command lands inside it, and the last busy cycle and the first idle cycle can both be sampled. With these values, the acknowledge-against-event race, the drop-on-busy error and the clearing done by the global reset command can each be driven on an exact edge.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;
  localparam int OP_W    = 5;
  localparam int PARAM_W = 11;
  localparam int CMD_W   = OP_W + PARAM_W;
  localparam int WIN_W   = 3;
  localparam int EVT_W   = 11;
  localparam int STS_W   = 16;

  // positions that carry a real event (bit 0 is the summary, bit 3 reserved)
  localparam logic [EVT_W-1:0] EVT_VALID = 11'b111_1111_0110;

  localparam logic [OP_W-1:0] OPC_GLB_RST = 5'h00;
  localparam logic [OP_W-1:0] OPC_WIN     = 5'h01;
  localparam logic [OP_W-1:0] OPC_ACK     = 5'h0D;
  localparam logic [OP_W-1:0] OPC_IRQ_EN  = 5'h0E;
  localparam logic [OP_W-1:0] OPC_IND_EN  = 5'h0F;

  typedef struct packed {
    logic glb_rst;
    logic win;
    logic ack;
    logic irq_en;
    logic ind_en;
  } ccp_strb_t;
endpackage

// File: rtl/ccp_cmd_seq.sv
`timescale 1ns/1ps
module ccp_cmd_seq
  import ccp_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [CMD_W-1:0]   cmd_data,
  output logic               busy,
  output logic               drop,
  output ccp_strb_t          strb,
  output logic [PARAM_W-1:0] param
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             accept;
  logic [OP_W-1:0]  opcode;

  always_comb begin
    busy   = (cnt_q != '0);
    accept = cmd_wr & ~busy;
    drop   = cmd_wr & busy;
    opcode = cmd_data[CMD_W-1:PARAM_W];
    param  = cmd_data[PARAM_W-1:0];

    strb.glb_rst = accept & (opcode == OPC_GLB_RST);
    strb.win     = accept & (opcode == OPC_WIN);
    strb.ack     = accept & (opcode == OPC_ACK);
    strb.irq_en  = accept & (opcode == OPC_IRQ_EN);
    strb.ind_en  = accept & (opcode == OPC_IND_EN);

    cnt_en = accept | busy;
    cnt_d  = accept ? CNT_LOAD : (cnt_q - CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ccp_evt_bank.sv
`timescale 1ns/1ps
module ccp_evt_bank
  import ccp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             ack,
  input  logic [EVT_W-1:0] ack_mask,
  input  logic             clr_all,
  output logic [EVT_W-1:0] evt_q
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (EVT_VALID[i]) begin : g_live
      logic q, d, en;
      always_comb begin
        en = clr_all | evt_i[i] | (ack & ack_mask[i]);
        if (clr_all)       d = 1'b0;
        else if (evt_i[i]) d = 1'b1;   // event beats acknowledge
        else               d = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= d;
      end
      assign evt_q[i] = q;
    end else begin : g_tie
      assign evt_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ccp_cfg_regs.sv
`timescale 1ns/1ps
module ccp_cfg_regs
  import ccp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ccp_strb_t          strb,
  input  logic [PARAM_W-1:0] param,
  input  logic               drop,
  output logic [WIN_W-1:0]   win_q,
  output logic [EVT_W-1:0]   irq_en_q,
  output logic [EVT_W-1:0]   ind_en_q,
  output logic               err_q,
  output logic               sta_clr_q
);
  logic [WIN_W-1:0] win_d;
  logic [EVT_W-1:0] irq_en_d, ind_en_d;
  logic             err_d;
  logic             win_en, irq_en_en, ind_en_en, err_en;

  always_comb begin
    win_en    = strb.win | strb.glb_rst;
    win_d     = strb.glb_rst ? '0 : param[WIN_W-1:0];
    irq_en_en = strb.irq_en | strb.glb_rst;
    irq_en_d  = strb.glb_rst ? '0 : (EVT_W'(param) & EVT_VALID);
    ind_en_en = strb.ind_en | strb.glb_rst;
    ind_en_d  = strb.glb_rst ? '0 : (EVT_W'(param) & EVT_VALID);
    err_en    = drop | strb.glb_rst;
    err_d     = ~strb.glb_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      irq_en_q  <= '0;
      ind_en_q  <= '0;
      err_q     <= 1'b0;
      sta_clr_q <= 1'b0;
    end else begin
      if (win_en)    win_q    <= win_d;
      if (irq_en_en) irq_en_q <= irq_en_d;
      if (ind_en_en) ind_en_q <= ind_en_d;
      if (err_en)    err_q    <= err_d;
      sta_clr_q <= strb.glb_rst;
    end
  end
endmodule

// File: rtl/ccp_cmd_port.sv
`timescale 1ns/1ps
module ccp_cmd_port
  import ccp_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_data,
  input  logic [10:0]      evt_i,
  output logic [15:0]      status_o,
  output logic [2:0]       win_sel_o,
  output logic             irq_o,
  output logic             cmd_err_o,
  output logic             sta_clr_o
);
  localparam int BUSY_POS = STS_W - WIN_W - 1;

  logic               busy, drop;
  ccp_strb_t          strb;
  logic [PARAM_W-1:0] param;
  logic [EVT_W-1:0]   evt_q, irq_en_q, ind_en_q, shown;
  logic [WIN_W-1:0]   win_q;
  logic               err_q, sta_clr_q, summary;

  ccp_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .busy(busy), .drop(drop), .strb(strb), .param(param)
  );

  ccp_evt_bank u_evt (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack(strb.ack),
    .ack_mask(EVT_W'(param)), .clr_all(strb.glb_rst), .evt_q(evt_q)
  );

  ccp_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .strb(strb), .param(param), .drop(drop),
    .win_q(win_q), .irq_en_q(irq_en_q), .ind_en_q(ind_en_q),
    .err_q(err_q), .sta_clr_q(sta_clr_q)
  );

  always_comb begin
    shown   = evt_q & ind_en_q;
    summary = |(evt_q & irq_en_q);
    status_o = '0;
    status_o[STS_W-1 -: WIN_W] = win_q;
    status_o[BUSY_POS]         = busy;
    status_o[EVT_W-1:1]        = shown[EVT_W-1:1];
    status_o[0]                = summary;
  end

  assign win_sel_o = win_q;
  assign irq_o     = summary;
  assign cmd_err_o = err_q;
  assign sta_clr_o = sta_clr_q;
endmodule

// File: rtl/ccp_port_chk.sv
`timescale 1ns/1ps
module ccp_port_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [15:0] status_o,
  input logic [2:0]  win_sel_o,
  input logic        irq_o,
  input logic        cmd_err_o,
  input logic        sta_clr_o
);
  logic acc;
  assign acc = cmd_wr & ~status_o[12];

  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> status_o[12]); // R8
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && status_o[12]) |=> cmd_err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err_o && !(acc && cmd_data[15:11] == 5'h00)) |=> cmd_err_o); // R9
  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(win_sel_o)); // R3
  AST_CLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sta_clr_o |-> (win_sel_o == 3'd0 && !cmd_err_o && !irq_o)); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !acc) |=> irq_o); // R7
endmodule

bind ccp_cmd_port ccp_port_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
  .status_o(status_o), .win_sel_o(win_sel_o), .irq_o(irq_o),
  .cmd_err_o(cmd_err_o), .sta_clr_o(sta_clr_o)
);

// File: tb/tb_ccp_cmd_port.sv
`timescale 1ns/1ps
module tb_ccp_cmd_port;
  localparam int B = 3;

  logic        clk, rst_n, cmd_wr;
  logic [15:0] cmd_data;
  logic [10:0] evt_i;
  logic [15:0] status_o;
  logic [2:0]  win_sel_o;
  logic        irq_o, cmd_err_o, sta_clr_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  ccp_cmd_port #(.BUSY_CYCLES(B)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .evt_i(evt_i), .status_o(status_o), .win_sel_o(win_sel_o),
    .irq_o(irq_o), .cmd_err_o(cmd_err_o), .sta_clr_o(sta_clr_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] op, input logic [10:0] prm);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = {op, prm};
    @(negedge clk); cmd_wr = 1'b0; cmd_data = '0;
  endtask

  task automatic idle();
    repeat (B) @(negedge clk);
  endtask

  task automatic cmd(input logic [4:0] op, input logic [10:0] prm);
    wr(op, prm); idle();
  endtask

  task automatic pulse(input logic [10:0] m);
    @(negedge clk); evt_i = m;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_wr = 0; cmd_data = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 status", status_o, 16'h0000);
    chk("R11 window", {13'd0, win_sel_o}, 16'd0);
    chk("R11 flags", {13'd0, irq_o, cmd_err_o, sta_clr_o}, 16'd0);
  endtask

  task automatic t_window();
    wr(5'h01, 11'h005);
    chk("R1 R3 window", {13'd0, win_sel_o}, 16'd5);
    chk("R2 status window", {13'd0, status_o[15:13]}, 16'd5);
    idle();
    cmd(5'h01, 11'h7FE);
    chk("R3 low bits only", {13'd0, win_sel_o}, 16'd6);
  endtask

  task automatic t_indication();
    pulse(11'h010);
    chk("R4 hidden while masked", status_o & 16'h07FE, 16'h0000);
    cmd(5'h0F, 11'h7FF);
    chk("R4 latched then shown", status_o & 16'h07FF, 16'h0010);
    pulse(11'h402);
    chk("R2 bit positions", status_o & 16'h0FFF, 16'h0412);
  endtask

  task automatic t_ack();
    cmd(5'h0D, 11'h012);
    chk("R5 masked clear", status_o & 16'h0FFF, 16'h0400);
    cmd(5'h0D, 11'h7FF);
    chk("R5 clear all", status_o & 16'h0FFF, 16'h0000);
  endtask

  task automatic t_race();
    pulse(11'h024);
    @(negedge clk); cmd_wr = 1; cmd_data = {5'h0D, 11'h024}; evt_i = 11'h004;
    @(negedge clk); cmd_wr = 0; cmd_data = '0; evt_i = '0;
    chk("R6 event beats ack", status_o & 16'h0FFF, 16'h0004);
    idle();
    cmd(5'h0D, 11'h7FF);
  endtask

  task automatic t_irq();
    cmd(5'h0F, 11'h000);
    cmd(5'h0E, 11'h004);
    pulse(11'h100);
    chk("R7 no irq unenabled", {15'd0, irq_o}, 16'd0);
    pulse(11'h004);
    chk("R7 irq set", {15'd0, irq_o}, 16'd1);
    chk("R7 summary bit", status_o & 16'h07FF, 16'h0001);
    cmd(5'h0D, 11'h004);
    chk("R7 irq cleared", {15'd0, irq_o}, 16'd0);
    cmd(5'h0D, 11'h7FF);
  endtask

  task automatic t_busy();
    wr(5'h01, 11'h002);
    chk("R8 busy start", {15'd0, status_o[12]}, 16'd1);
    repeat (B - 1) @(negedge clk);
    chk("R8 busy last", {15'd0, status_o[12]}, 16'd1);
    @(negedge clk);
    chk("R8 busy end", {15'd0, status_o[12]}, 16'd0);
    @(negedge clk); cmd_wr = 1; cmd_data = {5'h01, 11'h004};
    @(negedge clk); cmd_data = {5'h01, 11'h007};
    @(negedge clk); cmd_wr = 0; cmd_data = '0;
    chk("R9 dropped write", {13'd0, win_sel_o}, 16'd4);
    chk("R9 err set", {15'd0, cmd_err_o}, 16'd1);
    idle();
    cmd(5'h0E, 11'h000);
    chk("R9 err sticky", {15'd0, cmd_err_o}, 16'd1);
  endtask

  task automatic t_ignored();
    cmd(5'h0F, 11'h7FF);
    cmd(5'h0E, 11'h7FF);
    pulse(11'h009);
    chk("R12 evt bits 0 3 ignored", status_o & 16'h0FFF, 16'h0000);
    wr(5'h1F, 11'h7FF);
    chk("R12 unknown op busy", status_o, {3'd4, 1'b1, 12'h000});
    idle();
    chk("R12 unknown op no effect", {13'd0, win_sel_o}, 16'd4);
  endtask

  task automatic t_glb_rst();
    cmd(5'h01, 11'h005);
    pulse(11'h004);
    chk("R10 setup irq", {15'd0, irq_o}, 16'd1);
    @(negedge clk); cmd_wr = 1; cmd_data = 16'h0000; evt_i = 11'h010;
    @(negedge clk); cmd_wr = 0; evt_i = '0;
    chk("R10 strobe", {15'd0, sta_clr_o}, 16'd1);
    chk("R10 status", status_o, 16'h1000);
    chk("R10 err irq", {14'd0, cmd_err_o, irq_o}, 16'd0);
    @(negedge clk);
    chk("R10 strobe one cycle", {15'd0, sta_clr_o}, 16'd0);
    idle();
    cmd(5'h0F, 11'h7FF);
    chk("R10 events dropped", status_o & 16'h0FFF, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_window();
    t_indication();
    t_ack();
    t_race();
    t_irq();
    t_busy();
    t_ignored();
    t_glb_rst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule